// File: doc/BRIEF.md
# Segment and Block Address Translator

This block turns a 32-bit logical address from an instruction fetch or a load/store into either a physical address or a 52-bit interim virtual address. Two lookups run side by side on every request. The block lookup compares the upper address bits against a small set of variable-size block descriptors. Instruction fetches use one set of descriptors and data accesses use another. The segment lookup takes the top four address bits, selects one of sixteen segment registers, and joins that register's 24-bit virtual segment identifier with address bits 27:0.

When a block descriptor hits, its physical block number replaces the upper address bits, and the access is checked against the descriptor's protection code. When no descriptor hits, the response carries the interim virtual address and raises a flag that asks the page-table stage to finish the translation. All descriptor and segment registers are loaded through one configuration port. That port accepts writes only when the writer is in supervisor state.

Top module: `seg_blk_xlat`

## Requirements
- R1: On an accepted request, `rsp_vaddr` equals {segment register[addr[31:28]][23:0], addr[27:0]}. The low 12 bits are the untranslated page offset. A segment register is loaded with `cfg_sel`=0, where `cfg_idx` selects the register and `cfg_wdata[23:0]` is the identifier.
- R2: A descriptor's upper word holds the block tag in bits 31:17, the size mask in bits 12:2, the supervisor-valid flag in bit 1 and the user-valid flag in bit 0. Its lower word holds the physical block number in bits 31:17 and the protection code in bits 1:0. On a hit, `rsp_paddr` bits 31:17 are the physical block number where the mask bit is 0 and the address bit where the mask bit is 1. Bits 16:0 pass through unchanged.
- R3: Mask bit k (k = 0..10) covers address bit 17+k. A masked bit is ignored in the tag compare. Address bits 31:28 are always compared. An all-zero mask gives a 128 KB block and an all-ones mask gives a 256 MB block.
- R4: A descriptor can hit only if its valid flag for the request's privilege is set: supervisor-valid when `req_sup`=1 and user-valid when `req_sup`=0.
- R5: If several descriptors match, the one with the lowest index supplies the result.
- R6: Every response has exactly one of `rsp_blk_hit` and `rsp_walk` set. A block hit clears `rsp_walk` even when a segment translation also exists.
- R7: Instruction requests (`req_data`=0) use only the instruction descriptors, written with `cfg_sel`=1 (upper) and 2 (lower). Data requests use only the data descriptors, written with `cfg_sel`=3 (upper) and 4 (lower). `cfg_idx` 0..3 selects the descriptor.
- R8: A configuration write with `cfg_sup`=0 changes no register. It raises `priv_err` for exactly the one cycle after the write.
- R9: `rsp_prot_fault` is set only on a block hit whose protection code is 00, or whose code is 01 on a write. Codes 10 and 11 allow both reads and writes.
- R10: Each request produces its response one cycle later, with `rsp_valid` high for that cycle. After reset, `rsp_valid`, `priv_err` and every descriptor valid flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sup | input | 1 | Writer is in supervisor state |
| cfg_sel | input | 3 | Target: 0 segment, 1/2 instruction upper/lower, 3/4 data upper/lower |
| cfg_idx | input | 4 | Segment or descriptor index |
| cfg_wdata | input | 32 | Write data |
| priv_err | output | 1 | One-cycle pulse on a rejected user-state write |
| req_valid | input | 1 | Translation request |
| req_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| req_write | input | 1 | Access is a store |
| req_sup | input | 1 | Requester is in supervisor state |
| req_addr | input | 32 | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_blk_hit | output | 1 | Block descriptor hit |
| rsp_walk | output | 1 | Page lookup needed |
| rsp_prot_fault | output | 1 | Block protection violation |
| rsp_paddr | output | 32 | Physical address on a block hit, else 0 |
| rsp_vaddr | output | 52 | Interim virtual address |

## Verification
A corrupted segment register shows up in the upper 24 bits of `rsp_vaddr` on the first request that addresses that segment, one cycle after the request. A wrong descriptor tag, mask or valid flag shows up as a hit where a miss is expected, or the reverse, and appears at once as swapped `rsp_blk_hit` and `rsp_walk`. A wrong physical block number or priority choice shows up in the upper bits of `rsp_paddr` on the next hit. The bench sweeps all sixteen segments and all twelve block sizes, probing just inside and just outside each block, so every such state is reached within a few cycles.

// File: rtl/xlat_pkg.sv
// Shared widths and the configuration target encoding for the translator.
// Assumes a 32-bit logical address and 4 KB pages.
package xlat_pkg;
    localparam int ADDR_W     = 32;
    localparam int SEG_IDX_W  = 4;
    localparam int VSID_W     = 24;
    localparam int VA_W       = VSID_W + ADDR_W - SEG_IDX_W;
    localparam int BLK_LO     = 17;
    localparam int TAG_W      = ADDR_W - BLK_LO;
    localparam int MASK_W     = TAG_W - SEG_IDX_W;
    localparam int NUM_BLK    = 4;

    typedef enum logic [2:0] {
        TGT_SEG = 3'd0,
        TGT_IUP = 3'd1,
        TGT_ILO = 3'd2,
        TGT_DUP = 3'd3,
        TGT_DLO = 3'd4
    } cfg_tgt_e;
endpackage

// File: rtl/xlat_seg_file.sv
// Segment register file: one virtual segment identifier per segment.
// The caller gates writes by privilege. The read is combinational.
module xlat_seg_file #(
    parameter int SEG_IDX_W = 4,
    parameter int VSID_W    = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_IDX_W-1:0] wr_idx,
    input  logic [VSID_W-1:0]    wr_vsid,
    input  logic [SEG_IDX_W-1:0] rd_idx,
    output logic [VSID_W-1:0]    rd_vsid
);
    localparam int NUM_SEG = 1 << SEG_IDX_W;

    logic [VSID_W-1:0] seg_q [NUM_SEG];

    // Hold or load the segment identifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEG; i++) seg_q[i] <= '0;
        end else if (wr_en) begin
            seg_q[wr_idx] <= wr_vsid;
        end
    end

    // Select the segment for the lookup.
    assign rd_vsid = seg_q[rd_idx];

    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_idx)] == $past(wr_vsid)); // R1
endmodule

// File: rtl/xlat_blk_array.sv
// Block descriptor array with masked tag compare and lowest-index priority.
// Upper word: tag[31:17], mask[MASK_W+1:2], sup-valid[1], user-valid[0].
// Lower word: physical block number[31:17], protection[1:0].
// Assumes the caller has already gated writes by privilege and index range.
module xlat_blk_array #(
    parameter int NUM_BLK = 4,
    parameter int TAG_W   = 15,
    parameter int MASK_W  = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_upper,
    input  logic                       wr_lower,
    input  logic [$clog2(NUM_BLK)-1:0] wr_idx,
    input  logic [31:0]                wr_data,
    input  logic [TAG_W-1:0]           lk_tag,
    input  logic                       lk_sup,
    output logic                       lk_hit,
    output logic [TAG_W-1:0]           lk_pbn,
    output logic [1:0]                 lk_pp
);
    localparam int IDX_W = $clog2(NUM_BLK);
    localparam int FIX_W = TAG_W - MASK_W;

    logic [TAG_W-1:0]  tag_q  [NUM_BLK];
    logic [MASK_W-1:0] mask_q [NUM_BLK];
    logic [TAG_W-1:0]  pbn_q  [NUM_BLK];
    logic [1:0]        pp_q   [NUM_BLK];
    logic [NUM_BLK-1:0] sv_q, uv_q, match;
    logic [IDX_W-1:0]  sel;
    logic [TAG_W-1:0]  sel_mask;

    // Load the descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
            uv_q <= '0;
            for (int i = 0; i < NUM_BLK; i++) begin
                tag_q[i]  <= '0;
                mask_q[i] <= '0;
                pbn_q[i]  <= '0;
                pp_q[i]   <= '0;
            end
        end else begin
            if (wr_upper) begin
                tag_q[wr_idx]  <= wr_data[31 -: TAG_W];
                mask_q[wr_idx] <= wr_data[MASK_W+1:2];
                sv_q[wr_idx]   <= wr_data[1];
                uv_q[wr_idx]   <= wr_data[0];
            end
            if (wr_lower) begin
                pbn_q[wr_idx] <= wr_data[31 -: TAG_W];
                pp_q[wr_idx]  <= wr_data[1:0];
            end
        end
    end

    // Compare each entry against the tag under its own mask.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_cmp
        logic [TAG_W-1:0] ign;
        assign ign = {{FIX_W{1'b0}}, mask_q[g]};
        assign match[g] = (((lk_tag ^ tag_q[g]) & ~ign) == '0) &&
                          (lk_sup ? sv_q[g] : uv_q[g]);
    end

    // Pick the lowest-numbered matching entry.
    always_comb begin
        sel    = '0;
        lk_hit = 1'b0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel    = IDX_W'(i);
                lk_hit = 1'b1;
            end
        end
    end

    // Substitute the unmasked bits with the physical block number.
    assign sel_mask = {{FIX_W{1'b0}}, mask_q[sel]};
    assign lk_pbn   = (pbn_q[sel] & ~sel_mask) | (lk_tag & sel_mask);
    assign lk_pp    = pp_q[sel];

    AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_upper |=> tag_q[$past(wr_idx)] == $past(wr_data[31 -: TAG_W])); // R2
    AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && match[0]) |-> sel == '0); // R5
endmodule

// File: rtl/seg_blk_xlat.sv
// Top of the translator. It decodes the configuration port, runs the segment
// lookup and both descriptor arrays in parallel, and registers one response
// per request. Assumes privilege is given as an input on each port.
module seg_blk_xlat
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sup,
    input  logic [2:0]        cfg_sel,
    input  logic [3:0]        cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic              priv_err,
    input  logic              req_valid,
    input  logic              req_data,
    input  logic              req_write,
    input  logic              req_sup,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_blk_hit,
    output logic              rsp_walk,
    output logic              rsp_prot_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [VA_W-1:0]   rsp_vaddr
);
    localparam int IDX_W = $clog2(NUM_BLK);

    logic             wr_ok, blk_idx_ok;
    logic [VSID_W-1:0] vsid;
    logic             i_hit, d_hit, hit;
    logic [TAG_W-1:0] i_pbn, d_pbn, pbn;
    logic [1:0]       i_pp, d_pp, pp;
    logic             fault;

    // Accept a write only in supervisor state and for an existing entry.
    assign wr_ok      = cfg_we && cfg_sup;
    assign blk_idx_ok = int'(cfg_idx) < NUM_BLK;

    xlat_seg_file #(.SEG_IDX_W(SEG_IDX_W), .VSID_W(VSID_W)) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && cfg_sel == TGT_SEG),
        .wr_idx  (cfg_idx[SEG_IDX_W-1:0]),
        .wr_vsid (cfg_wdata[VSID_W-1:0]),
        .rd_idx  (req_addr[ADDR_W-1 -: SEG_IDX_W]),
        .rd_vsid (vsid)
    );

    xlat_blk_array #(.NUM_BLK(NUM_BLK), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_iblk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_upper (wr_ok && blk_idx_ok && cfg_sel == TGT_IUP),
        .wr_lower (wr_ok && blk_idx_ok && cfg_sel == TGT_ILO),
        .wr_idx   (cfg_idx[IDX_W-1:0]),
        .wr_data  (cfg_wdata),
        .lk_tag   (req_addr[ADDR_W-1:BLK_LO]),
        .lk_sup   (req_sup),
        .lk_hit   (i_hit),
        .lk_pbn   (i_pbn),
        .lk_pp    (i_pp)
    );

    xlat_blk_array #(.NUM_BLK(NUM_BLK), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_dblk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_upper (wr_ok && blk_idx_ok && cfg_sel == TGT_DUP),
        .wr_lower (wr_ok && blk_idx_ok && cfg_sel == TGT_DLO),
        .wr_idx   (cfg_idx[IDX_W-1:0]),
        .wr_data  (cfg_wdata),
        .lk_tag   (req_addr[ADDR_W-1:BLK_LO]),
        .lk_sup   (req_sup),
        .lk_hit   (d_hit),
        .lk_pbn   (d_pbn),
        .lk_pp    (d_pp)
    );

    // Choose the descriptor set by access kind and check protection.
    assign hit   = req_data ? d_hit : i_hit;
    assign pbn   = req_data ? d_pbn : i_pbn;
    assign pp    = req_data ? d_pp  : i_pp;
    assign fault = (pp == 2'b00) || (pp == 2'b01 && req_write);

    // Flag a rejected user-state write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_err <= 1'b0;
        else        priv_err <= cfg_we && !cfg_sup;
    end

    // Register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_blk_hit    <= 1'b0;
            rsp_walk       <= 1'b0;
            rsp_prot_fault <= 1'b0;
            rsp_paddr      <= '0;
            rsp_vaddr      <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_blk_hit    <= hit;
                rsp_walk       <= !hit;
                rsp_prot_fault <= hit && fault;
                rsp_paddr      <= hit ? {pbn, req_addr[BLK_LO-1:0]} : '0;
                rsp_vaddr      <= {vsid, req_addr[ADDR_W-SEG_IDX_W-1:0]};
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_walk ^ rsp_blk_hit)); // R6
    AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sup) |=> priv_err); // R8
    AST_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_sup) |=> !priv_err); // R8
    AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> rsp_blk_hit); // R9
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_vaddr[11:0] == $past(req_addr[11:0])); // R1
endmodule

// File: tb/seg_blk_xlat_test.sv
module seg_blk_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sup = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        priv_err;
    logic        req_valid = 1'b0, req_data = 1'b0, req_write = 1'b0, req_sup = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_blk_hit, rsp_walk, rsp_prot_fault;
    logic [31:0] rsp_paddr;
    logic [51:0] rsp_vaddr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seg_blk_xlat uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [3:0] idx, input logic [31:0] d, input logic sup);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d; cfg_sup = sup;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sup = 1'b0;
    endtask

    task automatic xl(input logic [31:0] a, input logic dat, input logic w, input logic sup);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = dat; req_write = w; req_sup = sup;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] up(input logic [31:0] base, input logic [10:0] m, input logic sv, input logic uv);
        return {base[31:17], 4'b0, m, sv, uv};
    endfunction

    function automatic logic [31:0] lo(input logic [31:0] base, input logic [1:0] pp);
        return {base[31:17], 15'b0, pp};
    endfunction

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset rsp_valid", rsp_valid, 0);
        check("R10 reset priv_err", priv_err, 0);
        xl(32'h5000_0000, 1'b0, 1'b0, 1'b1);
        check("R10 reset no hit", rsp_blk_hit, 0);
        @(negedge clk);
        check("R10 idle rsp_valid", rsp_valid, 0);

        // R1: sweep all segments
        for (int i = 0; i < 16; i++) wr(3'd0, 4'(i), 32'h00A0_0000 + i * 32'h1111, 1'b1);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a;
            logic [23:0] v;
            a = {4'(i), 28'h0} | ((i * 32'h0123_4567 + 32'h89) & 32'h0FFF_FFFF);
            v = 24'h00A0_0000 + 24'(i * 32'h1111);
            xl(a, i[0], 1'b0, i[1]);
            check("R1 vaddr", rsp_vaddr, {v, a[27:0]});
            check("R6 miss walk", rsp_walk, 1);
            check("R10 rsp_valid", rsp_valid, 1);
        end

        // R2 R3: block sizes 128 KB .. 256 MB
        for (int k = 0; k < 12; k++) begin
            logic [31:0] sz, ain;
            sz  = 32'h2_0000 << k;
            ain = 32'h5000_0000 | (32'h0ABC_DEF5 & (sz - 1));
            wr(3'd2, 4'd0, lo(32'h8000_0000, 2'b10), 1'b1);
            wr(3'd1, 4'd0, up(32'h5000_0000, 11'((1 << k) - 1), 1'b1, 1'b1), 1'b1);
            xl(ain, 1'b0, 1'b0, 1'b1);
            check("R3 hit inside", rsp_blk_hit, 1);
            check("R2 paddr", rsp_paddr, 32'h8000_0000 | (ain & (sz - 1)));
            check("R6 hit no walk", rsp_walk, 0);
            xl(32'h5000_0000 + sz, 1'b0, 1'b0, 1'b1);
            check("R3 miss above", rsp_blk_hit, 0);
            xl(32'h4FFF_FFFF, 1'b0, 1'b0, 1'b1);
            check("R3 miss below", rsp_blk_hit, 0);
        end
        wr(3'd1, 4'd0, 32'h0, 1'b1);

        // R4: privilege valid flags
        wr(3'd2, 4'd1, lo(32'h0100_0000, 2'b11), 1'b1);
        wr(3'd1, 4'd1, up(32'h3000_0000, 11'h0, 1'b1, 1'b0), 1'b1);
        xl(32'h3000_0040, 1'b0, 1'b0, 1'b0);
        check("R4 user miss on sup-only", rsp_blk_hit, 0);
        xl(32'h3000_0040, 1'b0, 1'b0, 1'b1);
        check("R4 sup hit", rsp_paddr, 32'h0100_0040);
        wr(3'd1, 4'd1, up(32'h3000_0000, 11'h0, 1'b0, 1'b1), 1'b1);
        xl(32'h3000_0040, 1'b0, 1'b0, 1'b0);
        check("R4 user hit", rsp_paddr, 32'h0100_0040);
        xl(32'h3000_0040, 1'b0, 1'b0, 1'b1);
        check("R4 sup miss on user-only", rsp_blk_hit, 0);

        // R7: separate sets
        wr(3'd4, 4'd0, lo(32'h9000_0000, 2'b10), 1'b1);
        wr(3'd3, 4'd0, up(32'h7000_0000, 11'h7FF, 1'b1, 1'b1), 1'b1);
        xl(32'h7123_4567, 1'b1, 1'b0, 1'b1);
        check("R7 data hit", rsp_paddr, 32'h9123_4567);
        xl(32'h7123_4567, 1'b0, 1'b0, 1'b1);
        check("R7 instr ignores data set", rsp_blk_hit, 0);
        xl(32'h3000_0040, 1'b1, 1'b0, 1'b0);
        check("R7 data ignores instr set", rsp_blk_hit, 0);

        // R5: priority
        wr(3'd4, 4'd1, lo(32'hB000_0000, 2'b10), 1'b1);
        wr(3'd3, 4'd1, up(32'h7000_0000, 11'h0, 1'b1, 1'b1), 1'b1);
        wr(3'd4, 4'd2, lo(32'hA000_0000, 2'b10), 1'b1);
        wr(3'd3, 4'd2, up(32'h7000_0000, 11'h0, 1'b1, 1'b1), 1'b1);
        xl(32'h7000_1234, 1'b1, 1'b0, 1'b1);
        check("R5 entry0 wins", rsp_paddr, 32'h9000_1234);
        wr(3'd3, 4'd0, 32'h0, 1'b1);
        xl(32'h7000_1234, 1'b1, 1'b0, 1'b1);
        check("R5 entry1 wins", rsp_paddr, 32'hB000_1234);
        wr(3'd3, 4'd1, 32'h0, 1'b1);
        xl(32'h7000_1234, 1'b1, 1'b0, 1'b1);
        check("R5 entry2 alone", rsp_paddr, 32'hA000_1234);

        // R9: protection codes
        wr(3'd3, 4'd3, up(32'h2000_0000, 11'h0, 1'b1, 1'b1), 1'b1);
        for (int p = 0; p < 4; p++) begin
            wr(3'd4, 4'd3, lo(32'h0400_0000, 2'(p)), 1'b1);
            xl(32'h2000_0100, 1'b1, 1'b0, 1'b1);
            check("R9 read fault", rsp_prot_fault, p == 0);
            xl(32'h2000_0100, 1'b1, 1'b1, 1'b1);
            check("R9 write fault", rsp_prot_fault, p < 2);
        end
        xl(32'h2100_0000, 1'b1, 1'b1, 1'b1);
        check("R9 no fault on miss", rsp_prot_fault, 0);

        // R8: user writes ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_idx = 4'd3; cfg_wdata = 32'hFF_FFFF; cfg_sup = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8 priv_err pulse", priv_err, 1);
        @(negedge clk);
        check("R8 priv_err one cycle", priv_err, 0);
        xl(32'h3ABC_D123, 1'b1, 1'b0, 1'b1);
        check("R8 segment unchanged", rsp_vaddr, {24'h00A0_3333, 28'hABC_D123});
        wr(3'd3, 4'd2, 32'h0, 1'b0);
        xl(32'h7000_1234, 1'b1, 1'b0, 1'b1);
        check("R8 descriptor unchanged", rsp_paddr, 32'hA000_1234);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule